// File: doc/BRIEF.md
# Indexed Block Configuration Register Slave (Two-Wire Bus)

This block is a target-only SMBus port for a clock-distribution chip. It holds five 8-bit configuration registers and drives their values in parallel to the clock-control logic. The registers are: a control byte, a per-output enable byte, a stop-mask byte, a spare byte that software may read and write, and a fixed identification byte. The SCL and SDA pins pass through a two-stage synchronizer and are edge-detected on the system clock. The block only pulls SDA low or releases it, through `sda_pull`. When the chip is powered down the bus is meaningless, so `pd_n` low holds the bus logic idle.

A host writes by sending the device address with W, a register offset, a byte count N that must be nonzero, and then N data bytes. These land in consecutive registers starting at the offset. A host reads by sending the address with W and the offset, then a repeated start and the address with R. The block answers with a byte count (registers left from the offset), then register contents, until the host NACKs. The register pointer persists between transactions and advances after every data byte.

The state machine has these states: `ST_IDLE`, `ST_ADDR` (address byte in), `ST_ADDR_ACK`, `ST_OFFS` (offset in), `ST_OFFS_ACK`, `ST_CNT` (count in), `ST_CNT_ACK`, `ST_WDATA` (data in), `ST_WDATA_ACK`, `ST_RD_TX` (byte out), `ST_RD_ACK` (host acknowledge sampled), `ST_RD_NXT` (prepare next byte) and `ST_WAIT` (ignore until start or stop).

Its transitions are:
- Any state goes to `ST_IDLE` on a stop or when `pd_n` is low, and to `ST_ADDR` on a start.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a match and to `ST_WAIT` otherwise.
- `ST_ADDR_ACK` goes to `ST_RD_TX` for R and to `ST_OFFS` for W.
- `ST_OFFS` goes to `ST_OFFS_ACK`, then to `ST_CNT`.
- `ST_CNT` goes to `ST_CNT_ACK` for a nonzero count and to `ST_WAIT` for zero.
- `ST_CNT_ACK` goes to `ST_WDATA`.
- `ST_WDATA` goes to `ST_WDATA_ACK` while the count is not used up and to `ST_WAIT` once it is. `ST_WDATA_ACK` returns to `ST_WDATA`.
- `ST_RD_TX` goes to `ST_RD_ACK`. `ST_RD_ACK` goes to `ST_RD_NXT` on ACK and to `ST_WAIT` on NACK. `ST_RD_NXT` returns to `ST_RD_TX`.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset the registers hold: control (index 0) = 0x07, enable (index 1) = 0xFF, stop mask (index 2) = 0x00, spare (index 3) = 0x00, identification (index 4) = the ID_VAL parameter (default 0xA5).
- R2: Only the 7-bit address 1101110 (ADDR byte 0xDC for write, 0xDD for read, address in bits 7:1) is acknowledged. After any other address, no byte is acknowledged and no register changes until the next start.
- R3: A block write (address+W, offset, count N, N data bytes) stores the data bytes into indices offset, offset+1, ... and acknowledges every byte. Data bytes beyond N are NACKed and discarded.
- R4: A count byte of 0 in a write is NACKed. The rest of the transfer is ignored, and no register changes.
- R5: Writes to index 4 and to indices 5 and above are acknowledged but discarded. Bits 5:3 of the control register always read 0. Its bits 7:6 and 2:0 are writable.
- R6: A block read returns first a count equal to 5 minus the offset (0 if the offset is 5 or more), then the registers from the offset upward. Indices 5 and above read 0x00. The host ends the read with a NACK.
- R7: A start or stop seen in the middle of a byte discards the partial byte. A stop returns to idle. A start begins a new address byte that is acknowledged normally.
- R8: While `pd_n` is low, SDA is never pulled and bus activity changes no register.
- R9: `sda_pull` begins pulling only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down; low forces the bus logic idle |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_ctrl | output | 8 | Control register (index 0) |
| cfg_oe | output | 8 | Per-output enable register (index 1) |
| cfg_stopmask | output | 8 | Stop-mask register (index 2) |
| cfg_rsvd | output | 8 | Spare read/write register (index 3) |
| cfg_id | output | 8 | Identification register (index 4) |

## Verification
The hardest situation to reach is a start or stop arriving part-way through a data byte after earlier bytes of the same block were already committed. The bench gets there with a bit-level task that clocks out only a few bits of a byte and then forms the condition while SCL is high. It then checks that the earlier bytes stayed written, that the partial byte left no trace, and that the address sent right after the start is acknowledged. Random block writes at random offsets and counts, some running past index 4, are interleaved with block reads to cover pointer wrap-past and the zero-count read.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    localparam int NREG = 5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_OFFS,
        ST_OFFS_ACK,
        ST_CNT,
        ST_CNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RD_TX,
        ST_RD_ACK,
        ST_RD_NXT,
        ST_WAIT
    } smb_state_e;

    // power-up value of register idx
    function automatic logic [7:0] reg_default(input int idx, input logic [7:0] id_val);
        case (idx)
            0:       return 8'h07;
            1:       return 8'hFF;
            4:       return id_val;
            default: return 8'h00;
        endcase
    endfunction

    // bits that a bus write may change
    function automatic logic [7:0] reg_wmask(input int idx);
        case (idx)
            0:       return 8'hC7;
            1, 2, 3: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_p;
    logic              sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_p  <= scl_ff[STAGES-1];
            sda_p  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs #(
    parameter int         NREG   = 5,
    parameter int         IW     = 8,
    parameter logic [7:0] ID_VAL = 8'hA5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [7:0]      wr_data,
    input  logic [IW-1:0]   rd_idx,
    output logic [7:0]      rd_data,
    output logic [NREG*8-1:0] regs_flat
);
    logic [7:0] regs_a [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [7:0] DEF  = smb_cfg_pkg::reg_default(g, ID_VAL);
        localparam logic [7:0] MASK = smb_cfg_pkg::reg_wmask(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_a[g] <= DEF;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                regs_a[g] <= (regs_a[g] & ~MASK) | (wr_data & MASK);
            end
        end
        assign regs_flat[g*8 +: 8] = regs_a[g];
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NREG; i++) begin
            if (rd_idx == IW'(i)) rd_data = regs_a[i];
        end
    end

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'b1101110,
    parameter logic [7:0] ID_VAL      = 8'hA5,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull,
    output logic [7:0] cfg_ctrl,
    output logic [7:0] cfg_oe,
    output logic [7:0] cfg_stopmask,
    output logic [7:0] cfg_rsvd,
    output logic [7:0] cfg_id
);
    import smb_cfg_pkg::*;

    localparam int IW = 8;
    localparam logic [IW-1:0] PTR_MAX = '1;

    smb_state_e state, state_nx;

    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]    shreg;
    logic [3:0]    bitcnt;
    logic [IW-1:0] ptr;
    logic [7:0]    cnt_left;
    logic [7:0]    cnt_byte;
    logic [7:0]    rd_data;
    logic          wr_en;
    logic          byte_in;
    logic          is_rx;
    logic          ack_nx;
    logic [NREG*8-1:0] regs_flat;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_cfg_regs #(.NREG(NREG), .IW(IW), .ID_VAL(ID_VAL)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (ptr),
        .wr_data   (shreg),
        .rd_idx    (ptr),
        .rd_data   (rd_data),
        .regs_flat (regs_flat)
    );

    assign cfg_ctrl     = regs_flat[7:0];
    assign cfg_oe       = regs_flat[15:8];
    assign cfg_stopmask = regs_flat[23:16];
    assign cfg_rsvd     = regs_flat[31:24];
    assign cfg_id       = regs_flat[39:32];

    // a full byte has been shifted and SCL just went low
    assign byte_in  = scl_fall && (bitcnt == 4'd8);
    assign is_rx    = (state == ST_ADDR) || (state == ST_OFFS) ||
                      (state == ST_CNT)  || (state == ST_WDATA);
    assign ack_nx   = (state_nx == ST_ADDR_ACK) || (state_nx == ST_OFFS_ACK) ||
                      (state_nx == ST_CNT_ACK)  || (state_nx == ST_WDATA_ACK);
    assign cnt_byte = (ptr < IW'(NREG)) ? (8'(NREG) - 8'(ptr)) : 8'h00;
    assign wr_en    = (state == ST_WDATA) && (state_nx == ST_WDATA_ACK);

    // next-state logic
    always_comb begin
        state_nx = state;
        if (!pd_n) begin
            state_nx = ST_IDLE;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR: begin
                    if (byte_in) state_nx = (shreg[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_WAIT;
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) state_nx = shreg[0] ? ST_RD_TX : ST_OFFS;
                end
                ST_OFFS: begin
                    if (byte_in) state_nx = ST_OFFS_ACK;
                end
                ST_OFFS_ACK: begin
                    if (scl_fall) state_nx = ST_CNT;
                end
                ST_CNT: begin
                    if (byte_in) state_nx = (shreg == 8'h00) ? ST_WAIT : ST_CNT_ACK;
                end
                ST_CNT_ACK: begin
                    if (scl_fall) state_nx = ST_WDATA;
                end
                ST_WDATA: begin
                    if (byte_in) state_nx = (cnt_left != 8'h00) ? ST_WDATA_ACK : ST_WAIT;
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) state_nx = ST_WDATA;
                end
                ST_RD_TX: begin
                    if (byte_in) state_nx = ST_RD_ACK;
                end
                ST_RD_ACK: begin
                    if (scl_rise) state_nx = sda_s ? ST_WAIT : ST_RD_NXT;
                end
                ST_RD_NXT: begin
                    if (scl_fall) state_nx = ST_RD_TX;
                end
                ST_WAIT:      state_nx = ST_WAIT;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath and SDA drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= 8'h00;
            bitcnt   <= 4'd0;
            ptr      <= '0;
            cnt_left <= 8'h00;
            sda_pull <= 1'b0;
        end else begin
            if ((state_nx != state) || start_det || stop_det) begin
                bitcnt <= 4'd0;
            end else if (scl_rise && (is_rx || (state == ST_RD_TX)) && (bitcnt != 4'd8)) begin
                bitcnt <= bitcnt + 4'd1;
            end

            if (pd_n && is_rx && scl_rise && (state_nx == state) && (bitcnt != 4'd8)) begin
                shreg <= {shreg[6:0], sda_s};
            end

            if ((state == ST_OFFS) && (state_nx == ST_OFFS_ACK)) begin
                ptr <= shreg;
            end

            if ((state == ST_CNT) && (state_nx == ST_CNT_ACK)) begin
                cnt_left <= shreg;
            end

            if (wr_en) begin
                cnt_left <= cnt_left - 8'h01;
                if (ptr != PTR_MAX) ptr <= ptr + 1'b1;
            end

            if (state_nx == ST_RD_TX) begin
                if (state == ST_ADDR_ACK) begin
                    shreg    <= cnt_byte;
                    sda_pull <= ~cnt_byte[7];
                end else if (state != ST_RD_TX) begin
                    shreg    <= rd_data;
                    sda_pull <= ~rd_data[7];
                    if (ptr != PTR_MAX) ptr <= ptr + 1'b1;
                end else if (scl_fall) begin
                    shreg    <= {shreg[6:0], 1'b0};
                    sda_pull <= ~shreg[6];
                end
            end else if (ack_nx) begin
                sda_pull <= 1'b1;
            end else begin
                sda_pull <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     pd_n,
    input logic                     sda_pull,
    input logic                     scl_s,
    input logic                     start_det,
    input logic [7:0]               cfg_ctrl,
    input logic [7:0]               cfg_oe,
    input smb_cfg_pkg::smb_state_e  state
);
    import smb_cfg_pkg::*;

    p_pd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> !sda_pull);

    p_pd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> ($stable(cfg_ctrl) && $stable(cfg_oe)));

    p_start_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && start_det) |=> (state == ST_ADDR));

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull);

    p_wait_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !sda_pull);

    p_pull_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !$past(scl_s));

    p_ctrl_rsvd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ctrl[5:3] == 3'b000));

endmodule

bind smb_cfg_slave smb_cfg_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_n      (pd_n),
    .sda_pull  (sda_pull),
    .scl_s     (scl_s),
    .start_det (start_det),
    .cfg_ctrl  (cfg_ctrl),
    .cfg_oe    (cfg_oe),
    .state     (state)
);

// File: tb/sim_smb_cfg_slave.sv
module sim_smb_cfg_slave;
    localparam int         CLK_P  = 10;
    localparam int         Q      = 8;
    localparam logic [7:0] ID_EXP = 8'hA5;
    localparam logic [6:0] DEV    = 7'b1101110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_n = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic [7:0] cfg_ctrl, cfg_oe, cfg_stopmask, cfg_rsvd, cfg_id;
    wire  sda_line = sda_m & ~sda_pull;

    always #(CLK_P/2) clk = ~clk;

    smb_cfg_slave #(.ID_VAL(ID_EXP)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .pd_n         (pd_n),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .sda_pull     (sda_pull),
        .cfg_ctrl     (cfg_ctrl),
        .cfg_oe       (cfg_oe),
        .cfg_stopmask (cfg_stopmask),
        .cfg_rsvd     (cfg_rsvd),
        .cfg_id       (cfg_id)
    );

    int   n_chk = 0;
    int   n_bad = 0;
    logic [7:0] model [5];
    logic [7:0] wbuf [8];
    logic       ackv [12];
    logic       pd_pull_seen = 1'b0;
    logic       pull_prev = 1'b0;
    int         r9_viol = 0;

    // R9 monitor: a new pull must begin while SCL is low
    always @(negedge clk) begin
        if (sda_pull && !pull_prev && scl_m) r9_viol++;
        pull_prev <= sda_pull;
        if (!pd_n && sda_pull) pd_pull_seen = 1'b1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
    endtask

    function automatic logic [7:0] wmask(input int i);
        case (i)
            0:       return 8'hC7;
            1, 2, 3: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_write(input int off, input int n);
        for (int k = 0; k < n; k++) begin
            int idx = off + k;
            if (idx < 5) model[idx] = (model[idx] & ~wmask(idx)) | (wbuf[k] & wmask(idx));
        end
    endtask

    task automatic check_regs(input string req);
        @(negedge clk);
        chk({req, " ctrl"}, cfg_ctrl, model[0]);
        chk({req, " oe"}, cfg_oe, model[1]);
        chk({req, " stopmask"}, cfg_stopmask, model[2]);
        chk({req, " spare"}, cfg_rsvd, model[3]);
        chk({req, " id"}, cfg_id, model[4]);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            sda_m = b[i]; hold(Q);
            scl_m = 1'b1; hold(2*Q);
            scl_m = 1'b0; hold(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        @(negedge clk) ack = !sda_line;
        hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic ack_it);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; hold(Q);
            scl_m = 1'b1; hold(Q);
            @(negedge clk) b[i] = sda_line;
            hold(Q);
            scl_m = 1'b0; hold(Q);
        end
        sda_m = ack_it ? 1'b0 : 1'b1; hold(Q);
        scl_m = 1'b1; hold(2*Q);
        scl_m = 1'b0; hold(Q);
        sda_m = 1'b1;
    endtask

    task automatic wr_block(input logic [6:0] a, input logic [7:0] off,
                            input logic [7:0] n, input int nsend);
        for (int k = 0; k < 12; k++) ackv[k] = 1'bx;
        bus_start();
        send_byte({a, 1'b0}, ackv[0]);
        send_byte(off, ackv[1]);
        send_byte(n, ackv[2]);
        for (int k = 0; k < nsend; k++) send_byte(wbuf[k], ackv[3+k]);
        bus_stop();
        hold(Q);
    endtask

    task automatic rd_check(input int off, input string req);
        logic       a;
        logic [7:0] b;
        int         cnt_exp, nrd;
        cnt_exp = (off < 5) ? 5 - off : 0;
        bus_start();
        send_byte({DEV, 1'b0}, a);
        chk({req, " read addr W ack"}, a, 1'b1);
        send_byte(8'(off), a);
        bus_start();
        send_byte({DEV, 1'b1}, a);
        chk({req, " read addr R ack"}, a, 1'b1);
        nrd = (cnt_exp > 0) ? cnt_exp : 1;
        recv_byte(b, 1'b1);
        chk({req, " count"}, b, 8'(cnt_exp));
        for (int k = 0; k < nrd; k++) begin
            recv_byte(b, k != nrd - 1);
            chk({req, " data"}, b, (off + k < 5) ? model[off + k] : 8'h00);
        end
        bus_stop();
        hold(Q);
    endtask

    initial begin
        #(CLK_P * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic       a;
        int unsigned seed_v;
        seed_v = $urandom(32'h5EED_0001);
        model[0] = 8'h07; model[1] = 8'hFF; model[2] = 8'h00;
        model[3] = 8'h00; model[4] = ID_EXP;
        hold(5);
        rst_n = 1'b1;
        hold(5);

        // R1: reset values
        check_regs("R1");

        // R3 / R5: full write from offset 0
        wbuf[0] = 8'hFF; wbuf[1] = 8'h3C; wbuf[2] = 8'hA5; wbuf[3] = 8'h77; wbuf[4] = 8'h12;
        wr_block(DEV, 8'd0, 8'd5, 5);
        chk("R2 addr ack", ackv[0], 1'b1);
        for (int k = 1; k < 8; k++) chk("R3 byte ack", ackv[k], 1'b1);
        model_write(0, 5);
        check_regs("R5");

        // R6: reads at several offsets
        rd_check(0, "R6 off0");
        rd_check(3, "R6 off3");
        rd_check(6, "R6 off6");

        // R2: foreign address ignored
        wbuf[0] = 8'h00; wbuf[1] = 8'h00;
        wr_block(7'b1101111, 8'd1, 8'd2, 2);
        for (int k = 0; k < 5; k++) chk("R2 no ack", ackv[k], 1'b0);
        check_regs("R2");

        // R4: zero count
        wbuf[0] = 8'h5A;
        wr_block(DEV, 8'd1, 8'd0, 1);
        chk("R4 addr ack", ackv[0], 1'b1);
        chk("R4 count nack", ackv[2], 1'b0);
        chk("R4 data nack", ackv[3], 1'b0);
        check_regs("R4");

        // R5: writes to index 4 and beyond
        wbuf[0] = 8'h00; wbuf[1] = 8'h11; wbuf[2] = 8'h22;
        wr_block(DEV, 8'd4, 8'd3, 3);
        for (int k = 3; k < 6; k++) chk("R5 ack", ackv[k], 1'b1);
        check_regs("R5 ro");

        // R3: bytes beyond the count
        wbuf[0] = 8'h81; wbuf[1] = 8'h42;
        wr_block(DEV, 8'd2, 8'd1, 2);
        chk("R3 first ack", ackv[3], 1'b1);
        chk("R3 excess nack", ackv[4], 1'b0);
        model_write(2, 1);
        check_regs("R3 excess");

        // R7: start in the middle of the second data byte
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'd1, a);
        send_byte(8'd2, a);
        send_byte(8'h11, a);
        send_bits(8'hEE, 3);
        bus_start();
        send_byte({DEV, 1'b0}, a);
        chk("R7 addr after start", a, 1'b1);
        send_byte(8'd3, a);
        send_byte(8'd1, a);
        send_byte(8'h99, a);
        bus_stop();
        hold(Q);
        wbuf[0] = 8'h11; model_write(1, 1);
        wbuf[0] = 8'h99; model_write(3, 1);
        check_regs("R7 start");

        // R7: stop in the middle of a data byte
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'd2, a);
        send_byte(8'd1, a);
        send_bits(8'h00, 4);
        bus_stop();
        hold(Q);
        check_regs("R7 stop");
        rd_check(1, "R7 after stop");

        // R8: power-down
        pd_n = 1'b0;
        hold(4);
        wbuf[0] = 8'h00; wbuf[1] = 8'h00;
        wr_block(DEV, 8'd0, 8'd2, 2);
        for (int k = 0; k < 5; k++) chk("R8 no ack", ackv[k], 1'b0);
        chk("R8 no pull", pd_pull_seen, 1'b0);
        check_regs("R8");
        pd_n = 1'b1;
        hold(4 * Q);

        // R3 / R6: random block writes with periodic readback
        for (int it = 0; it < 30; it++) begin
            int off, n;
            off = $urandom_range(0, 6);
            n   = $urandom_range(1, 4);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            wr_block(DEV, 8'(off), 8'(n), n);
            for (int k = 0; k < n + 3; k++) chk("R3 rand ack", ackv[k], 1'b1);
            model_write(off, n);
            check_regs("R3 rand");
            if (it % 5 == 4) rd_check($urandom_range(0, 5), "R6 rand");
        end

        // R9: pull onset timing over the whole run
        chk("R9 pull while scl high", r9_viol, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule